// File: doc/BRIEF.md
# Floating-Point Compare Condition Queue

This block folds the outcome of a floating-point compare into the compare-condition bits of a 32-bit floating-point status word. It does not compare numbers itself. A comparator upstream classifies the operands into one of four relations and reports whether a signalling NaN was present. The block then receives that relation, a 5-bit condition selector, a 3-bit target index and the current status word. One clock later it presents the updated word together with a one-cycle valid strobe.

The selector does two jobs. Its top four bits choose which relations make the condition true. Its low bit chooses a signalling or a quiet compare. The target index chooses the kind of update:

- An index of zero pushes the new result into the primary condition bit. The previous primary bit and the older results shift one place down a history queue.
- A nonzero index writes the result into a single addressed condition bit and leaves every other bit in place.

When an unordered result raises the invalid exception, the exception bookkeeping is applied to the word first and the condition update second. If the invalid trap is enabled, a trap indication is raised.

Top module: `fpcc_queue`

## Requirements
- R1: The result bit is taken from the selector by relation code: greater (code 0) picks selector bit 4, less (code 1) picks bit 3, equal (code 2) picks bit 2, unordered (code 3) picks bit 1.
- R2: A nonzero target index y (1 to 7) writes the result into word bit 21-(y-1), so y=1 writes bit 21 and y=7 writes bit 15. All other condition bits, including bit 26, keep their input values.
- R3: A target index of 0 writes the result into bit 26 (primary condition). For every k from 15 to 25, output bit k takes input bit k+1. The old bit 15 is dropped, and bits outside 26..15 are unchanged.
- R4: An unordered relation raises invalid when selector bit 0 is 1 (signalling compare). When selector bit 0 is 0 (quiet compare), it raises invalid only if snan_i is 1. Other relations never raise invalid.
- R5: When invalid is raised with the enable bit (bit 4) clear, the sticky invalid flag (bit 31) is set. With the enable bit set, the trap bit (bit 6) is set instead, bit 31 is left as it was, and trap_o is 1 for that result.
- R6: The exception update and the condition update both appear in the same output word.
- R7: A relation code from 4 to 7 makes err_o 1 and trap_o 0, and word_o equals word_i unchanged.
- R8: Each update appears on word_o one clock after upd_i, with valid_o high for exactly that one cycle. Without upd_i, word_o, err_o and trap_o hold their values.
- R9: After reset, valid_o, err_o and trap_o are 0 and word_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Apply one compare result this cycle |
| rel_i | input | 3 | Relation code: 0 greater, 1 less, 2 equal, 3 unordered, others illegal |
| sel_i | input | 5 | Condition selector; bit 0 selects signalling compare |
| y_i | input | 3 | Target index; 0 queues, nonzero addresses one bit |
| snan_i | input | 1 | An operand was a signalling NaN |
| word_i | input | 32 | Current status word |
| word_o | output | 32 | Updated status word |
| valid_o | output | 1 | One-cycle strobe marking a new word_o |
| err_o | output | 1 | The last update carried an illegal relation code |
| trap_o | output | 1 | The last update raised an enabled invalid trap |

## Verification
Each relation is tried with a selector that makes it true and with one that makes it false. This separates correct bit picking from a stuck result. Targeted writes go to both ends of the addressable range, setting a bit in an all-zero word and clearing one in an all-ones word, which exposes off-by-one addressing and collateral damage. Queued updates run back to back on patterned words, and one of them has a set bit at the queue tail and just below it, which shows whether the shift direction and the drop point are right. Unordered results are applied under quiet and signalling selectors with the trap enable both clear and set, and illegal relation codes are fed with words that would otherwise be modified.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
   localparam int SEL_W = 5;
   localparam int REL_W = 3;

   typedef enum logic [REL_W-1:0] {
      REL_GT = 3'd0,
      REL_LT = 3'd1,
      REL_EQ = 3'd2,
      REL_UN = 3'd3
   } rel_e;
endpackage

// File: rtl/fpcc_pick.sv
module fpcc_pick
   import fpcc_pkg::*;
(
   input  logic [REL_W-1:0] rel_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             snan_i,
   output logic             res_o,
   output logic             legal_o,
   output logic             invalid_o
);
   always_comb begin
      res_o     = 1'b0;
      legal_o   = 1'b1;
      invalid_o = 1'b0;
      case (rel_i)
         REL_GT: res_o = sel_i[4];
         REL_LT: res_o = sel_i[3];
         REL_EQ: res_o = sel_i[2];
         REL_UN: begin
            res_o     = sel_i[1];
            // signalling compares trap on any NaN, quiet ones only on SNaN
            invalid_o = sel_i[0] | snan_i;
         end
         default: legal_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpcc_excpt.sv
module fpcc_excpt #(
   parameter int WORD_W     = 32,
   parameter int V_ENA_POS  = 4,
   parameter int V_FLAG_POS = 31,
   parameter int TRAP_POS   = 6
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              raise_i,
   output logic [WORD_W-1:0] word_o,
   output logic              trap_o
);
   generate
      if (V_ENA_POS >= WORD_W || V_FLAG_POS >= WORD_W || TRAP_POS >= WORD_W) begin : g_bad
         $error("fpcc_excpt: exception bit outside status word");
      end
   endgenerate

   always_comb begin
      word_o = word_i;
      trap_o = 1'b0;
      if (raise_i) begin
         if (word_i[V_ENA_POS]) begin
            word_o[TRAP_POS] = 1'b1;
            trap_o           = 1'b1;
         end else begin
            word_o[V_FLAG_POS] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpcc_cond.sv
module fpcc_cond #(
   parameter int WORD_W  = 32,
   parameter int C_POS   = 26,
   parameter int CQ_LEN  = 11,
   parameter int CA0_POS = 21,
   parameter int Y_W     = 3
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [Y_W-1:0]    y_i,
   input  logic              res_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int CQ_LO  = C_POS - CQ_LEN;
   localparam int Y_MAX  = (1 << Y_W) - 1;
   localparam int CA_LO  = CA0_POS - (Y_MAX - 1);

   generate
      if (C_POS >= WORD_W || CQ_LO < 0) begin : g_bad_q
         $error("fpcc_cond: queue does not fit in status word");
      end
      if (CA_LO < 0 || CA0_POS >= WORD_W || (CA0_POS >= C_POS && CA_LO <= C_POS)) begin : g_bad_t
         $error("fpcc_cond: targeted range invalid or covers primary bit");
      end
   endgenerate

   logic queued;
   assign queued = (y_i == '0);

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      localparam int YHIT = CA0_POS - i + 1;
      logic hit;
      if (YHIT >= 1 && YHIT <= Y_MAX) begin : g_tgt
         assign hit = (y_i == YHIT[Y_W-1:0]);
      end else begin : g_not
         assign hit = 1'b0;
      end

      if (i == C_POS) begin : g_c
         assign word_o[i] = (queued || hit) ? res_i : word_i[i];
      end else if (i >= CQ_LO && i < C_POS) begin : g_q
         assign word_o[i] = queued ? word_i[i+1] : (hit ? res_i : word_i[i]);
      end else begin : g_o
         assign word_o[i] = hit ? res_i : word_i[i];
      end
   end
endmodule

// File: rtl/fpcc_queue.sv
module fpcc_queue
   import fpcc_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int C_POS      = 26,
   parameter int CQ_LEN     = 11,
   parameter int CA0_POS    = 21,
   parameter int Y_W        = 3,
   parameter int V_ENA_POS  = 4,
   parameter int V_FLAG_POS = 31,
   parameter int TRAP_POS   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_i,
   input  logic [2:0]        rel_i,
   input  logic [4:0]        sel_i,
   input  logic [Y_W-1:0]    y_i,
   input  logic              snan_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o,
   output logic              err_o,
   output logic              trap_o
);
   logic              res, legal, invalid, trap_n;
   logic [WORD_W-1:0] w_exc, w_cond, w_next;

   fpcc_pick u_pick (
      .rel_i    (rel_i),
      .sel_i    (sel_i),
      .snan_i   (snan_i),
      .res_o    (res),
      .legal_o  (legal),
      .invalid_o(invalid)
   );

   fpcc_excpt #(
      .WORD_W    (WORD_W),
      .V_ENA_POS (V_ENA_POS),
      .V_FLAG_POS(V_FLAG_POS),
      .TRAP_POS  (TRAP_POS)
   ) u_excpt (
      .word_i (word_i),
      .raise_i(invalid),
      .word_o (w_exc),
      .trap_o (trap_n)
   );

   fpcc_cond #(
      .WORD_W (WORD_W),
      .C_POS  (C_POS),
      .CQ_LEN (CQ_LEN),
      .CA0_POS(CA0_POS),
      .Y_W    (Y_W)
   ) u_cond (
      .word_i(w_exc),
      .y_i   (y_i),
      .res_i (res),
      .word_o(w_cond)
   );

   assign w_next = legal ? w_cond : word_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o  <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         trap_o  <= 1'b0;
      end else begin
         valid_o <= upd_i;
         if (upd_i) begin
            word_o <= w_next;
            err_o  <= ~legal;
            trap_o <= legal & trap_n;
         end
      end
   end

   // R8: one strobe per update, one cycle later
   p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> valid_o);
   p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> !valid_o);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(word_o) && $stable(err_o) && $stable(trap_o));
   // R7: illegal relation passes the word through
   p_illegal_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && rel_i > 3'd3) |=> err_o && !trap_o && (word_o == $past(word_i)));
   // R3: old primary bit lands at the queue head
   p_queue_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && rel_i <= 3'd3 && y_i == '0) |=> word_o[C_POS-1] == $past(word_i[C_POS]));
   // R2: targeted write never touches the primary bit
   p_target_keeps_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && rel_i <= 3'd3 && y_i != '0) |=> word_o[C_POS] == $past(word_i[C_POS]));
   // R5: a reported trap is always recorded in the word
   p_trap_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> word_o[TRAP_POS]);
endmodule

// File: tb/fpcc_queue_bench.sv
module fpcc_queue_bench;
   typedef struct packed {
      logic [2:0]  rel;
      logic [4:0]  sel;
      logic [2:0]  y;
      logic        snan;
      logic [31:0] win;
      logic [31:0] wexp;
      logic        err;
      logic        trap;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 5'b10000, 3'd1, 1'b0, 32'h0000_0000, 32'h0020_0000, 1'b0, 1'b0, 4'd1}, // R1 R2 y=1
      '{3'd1, 5'b10000, 3'd1, 1'b0, 32'hFFFF_FFFF, 32'hFFDF_FFFF, 1'b0, 1'b0, 4'd1}, // R1 R2 clear
      '{3'd2, 5'b00100, 3'd7, 1'b0, 32'h0000_0000, 32'h0000_8000, 1'b0, 1'b0, 4'd2}, // R2 y=7
      '{3'd3, 5'b00010, 3'd3, 1'b0, 32'h0000_0000, 32'h0008_0000, 1'b0, 1'b0, 4'd4}, // R4 quiet
      '{3'd3, 5'b00011, 3'd3, 1'b0, 32'h0000_0000, 32'h8008_0000, 1'b0, 1'b0, 4'd6}, // R4 R6 flag
      '{3'd3, 5'b00011, 3'd2, 1'b0, 32'h0000_0010, 32'h0010_0050, 1'b0, 1'b1, 4'd5}, // R5 trap
      '{3'd3, 5'b00010, 3'd2, 1'b1, 32'h0000_0000, 32'h8010_0000, 1'b0, 1'b0, 4'd4}, // R4 snan
      '{3'd0, 5'b10000, 3'd0, 1'b0, 32'h0400_0000, 32'h0600_0000, 1'b0, 1'b0, 4'd3}, // R3 push 1
      '{3'd1, 5'b00000, 3'd0, 1'b0, 32'h0600_0000, 32'h0300_0000, 1'b0, 1'b0, 4'd3}, // R3 push 0
      '{3'd2, 5'b00100, 3'd0, 1'b0, 32'h0800_C000, 32'h0C00_4000, 1'b0, 1'b0, 4'd3}, // R3 tail
      '{3'd5, 5'b11111, 3'd0, 1'b1, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0, 4'd7}, // R7
      '{3'd4, 5'b11111, 3'd3, 1'b0, 32'h0000_0010, 32'h0000_0010, 1'b1, 1'b0, 4'd7}  // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd = 1'b0;
   logic [2:0]  rel = '0;
   logic [4:0]  sel = '0;
   logic [2:0]  y = '0;
   logic        snan = 1'b0;
   logic [31:0] win = '0;
   logic [31:0] wout;
   logic        valid, err, trap;
   int          n_run = 0;
   int          n_fail = 0;
   logic        done = 1'b0;

   always #2.5 clk = ~clk;

   fpcc_queue u_fpcc_queue (
      .clk(clk), .rst_n(rst_n), .upd_i(upd), .rel_i(rel), .sel_i(sel),
      .y_i(y), .snan_i(snan), .word_i(win), .word_o(wout),
      .valid_o(valid), .err_o(err), .trap_o(trap)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      upd = 1'b1; rel = v.rel; sel = v.sel; y = v.y; snan = v.snan; win = v.win;
      @(negedge clk);
      upd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 word", wout, 32'h0);
      chk("R9 flags", {29'd0, valid, err, trap}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         chk($sformatf("R%0d word v%0d", VECS[i].req, i), wout, VECS[i].wexp);
         chk($sformatf("R%0d err/trap v%0d", VECS[i].req, i),
             {30'd0, err, trap}, {30'd0, VECS[i].err, VECS[i].trap});
         chk($sformatf("R8 valid v%0d", i), {31'd0, valid}, 32'd1);
      end

      // R8: idle cycles, strobe drops and word holds while input changes
      win = 32'hDEAD_BEEF; rel = 3'd3; sel = 5'b11111;
      @(negedge clk);
      chk("R8 strobe drops", {31'd0, valid}, 32'd0);
      chk("R8 word holds", wout, 32'h0000_0010);
      chk("R8 err holds", {31'd0, err}, 32'd1);

      // R8 back-to-back updates, each visible one cycle later
      @(negedge clk);
      upd = 1'b1; rel = 3'd0; sel = 5'b10000; y = 3'd0; snan = 1'b0; win = 32'h0;
      @(negedge clk);
      chk("R3 b2b first", wout, 32'h0400_0000);
      win = 32'h0400_0000; rel = 3'd1;
      @(negedge clk);
      upd = 1'b0;
      chk("R3 b2b second", wout, 32'h0200_0000);
      chk("R8 b2b valid", {31'd0, valid}, 32'd1);

      // R5 trap clears on the next update without exception
      apply('{3'd2, 5'b00100, 3'd1, 1'b0, 32'h0000_0010, 32'h0020_0010, 1'b0, 1'b0, 4'd5});
      chk("R5 no trap", {31'd0, trap}, 32'd0);
      chk("R5 word", wout, 32'h0020_0010);

      // R9 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 reset again", wout, 32'h0);
      chk("R9 reset flags", {29'd0, valid, err, trap}, 32'h0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule